// File: doc/BRIEF.md
# Latched/Registered Bidirectional Bus Transceiver

This block passes an 18-bit word between two buses, called side A and side B. It has one independent path for each direction. Each path owns a single storage register that can work in three ways. It can be transparent, so the destination follows the source in the same cycle. It can capture the source on a rising edge of a per-direction strobe. Or it can hold its last value while the strobe stays steady. A per-direction enable says whether the destination side is driven. The enable for A-to-B is active high and the enable for B-to-A is active low.

The design runs on one system clock. The per-direction strobes are treated as sampled data signals, and their rising edges are found against the system clock. The block does not drive any pins in three states. Each side gets a data-out vector and a per-bit enable vector, and a pad wrapper can use these to drive its outputs or float them. When both directions are enabled at the same time, a contention flag is raised. Nothing else prevents both directions from driving at once.

Top module: `bus_xcvr18`

## Requirements
- R1: While `rst` is high on a clock edge, both storage registers are cleared to zero. After reset, with both latch controls low, `b_dout` and `a_dout` read 0.
- R2: While `le_ab` is high, `b_dout` equals `a_din` in the same cycle, with no clock edge needed.
- R3: While `le_ab` is low, a rising edge seen on `stb_ab` loads `a_din` into the A-to-B register. A rising edge is `stb_ab` high at a clock edge after it was low at the previous edge. The new value appears on `b_dout` after that clock edge.
- R4: While `le_ab` is low and `stb_ab` stays low or stays high, `b_dout` keeps the stored value whatever `a_din` does.
- R5: When `le_ab` falls, `b_dout` keeps the `a_din` value sampled at the last clock edge while `le_ab` was high.
- R6: If `stb_ab` is already high when `le_ab` falls, nothing is captured until `stb_ab` goes low and then high again.
- R7: `b_oe` is all ones when `oe_ab` is 1 and all zeros when `oe_ab` is 0 (active high).
- R8: `a_oe` is all ones when `oe_ba_n` is 0 and all zeros when `oe_ba_n` is 1 (active low).
- R9: The B-to-A path follows the same transparent, capture and hold rules from `b_din` to `a_dout`, using `le_ba` and `stb_ba`.
- R10: `contention` is 1 exactly when `oe_ab` is 1 and `oe_ba_n` is 0.
- R11: The strobe, latch control and data of one direction never change the output of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_din | input | 18 | Data received from side A |
| le_ab | input | 1 | A-to-B transparency control (1 = transparent) |
| stb_ab | input | 1 | A-to-B capture strobe, acts on its rising edge |
| oe_ab | input | 1 | A-to-B drive enable, active high |
| b_dout | output | 18 | Data toward side B |
| b_oe | output | 18 | Per-bit drive enable for side B |
| b_din | input | 18 | Data received from side B |
| le_ba | input | 1 | B-to-A transparency control (1 = transparent) |
| stb_ba | input | 1 | B-to-A capture strobe, acts on its rising edge |
| oe_ba_n | input | 1 | B-to-A drive enable, active low |
| a_dout | output | 18 | Data toward side A |
| a_oe | output | 18 | Per-bit drive enable for side A |
| contention | output | 1 | Both directions enabled at once |

## Verification
Assertions check the register rules on every cycle in both paths. A detected strobe edge loads the source, a quiet strobe leaves the register unchanged, and transparency reloads it each cycle. They also check that every enable vector is uniform and that contention always comes with both enables active. Some behaviours can only be shown by the bench's scenarios, because they depend on sequences the properties do not track. These are the values seen right after reset, that a strobe held high across the fall of the latch control does not capture, the polarity of each enable, and that the two directions are isolated from each other.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Polarity of a path's drive enable input
  typedef enum logic {
    OE_ACT_HIGH = 1'b0,
    OE_ACT_LOW  = 1'b1
  } oe_pol_e;

  localparam int unsigned XCVR_WIDTH = 18;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;

  // a detected edge cannot repeat on the following cycle
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R3
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W   = XCVR_WIDTH,
  parameter oe_pol_e     POL = OE_ACT_HIGH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         strobe,
  input  logic         oe_in,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe_vec,
  output logic         enabled
);
  logic         rise;
  logic [W-1:0] stored;

  xcvr_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rise   (rise)
  );

  // one register serves both transparent reload and edge capture
  always_ff @(posedge clk) begin
    if (rst)            stored <= '0;
    else if (le || rise) stored <= din;
  end

  assign dout = le ? din : stored;

  generate
    if (POL == OE_ACT_LOW) begin : g_pol_low
      assign enabled = ~oe_in;
    end else begin : g_pol_high
      assign enabled = oe_in;
    end
  endgenerate

  assign oe_vec = {W{enabled}};

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!le && rise) |=> (stored == $past(din))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!le && !rise) |=> $stable(stored)); // R4
  AST_TRANSP_LOAD: assert property (@(posedge clk) disable iff (rst)
    le |=> (stored == $past(din))); // R5
  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (oe_vec == '0) || (oe_vec == '1)); // R7
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_din,
  input  logic         le_ab,
  input  logic         stb_ab,
  input  logic         oe_ab,
  output logic [W-1:0] b_dout,
  output logic [W-1:0] b_oe,
  input  logic [W-1:0] b_din,
  input  logic         le_ba,
  input  logic         stb_ba,
  input  logic         oe_ba_n,
  output logic [W-1:0] a_dout,
  output logic [W-1:0] a_oe,
  output logic         contention
);
  logic en_ab, en_ba;

  xcvr_path #(.W(W), .POL(OE_ACT_HIGH)) u_ab (
    .clk     (clk),
    .rst     (rst),
    .din     (a_din),
    .le      (le_ab),
    .strobe  (stb_ab),
    .oe_in   (oe_ab),
    .dout    (b_dout),
    .oe_vec  (b_oe),
    .enabled (en_ab)
  );

  xcvr_path #(.W(W), .POL(OE_ACT_LOW)) u_ba (
    .clk     (clk),
    .rst     (rst),
    .din     (b_din),
    .le      (le_ba),
    .strobe  (stb_ba),
    .oe_in   (oe_ba_n),
    .dout    (a_dout),
    .oe_vec  (a_oe),
    .enabled (en_ba)
  );

  assign contention = en_ab & en_ba;

  AST_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    contention |-> (b_oe[0] && a_oe[0])); // R10
endmodule

// File: tb/bus_xcvr18_bench.sv
module bus_xcvr18_bench;
  localparam int W = 18;

  typedef struct {
    string      req;
    int         sel;   // 0 b_dout, 1 a_dout, 2 b_oe, 3 a_oe, 4 contention
    logic [W-1:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_din, b_din;
  logic le_ab, stb_ab, oe_ab, le_ba, stb_ba, oe_ba_n;
  logic [W-1:0] b_dout, b_oe, a_dout, a_oe;
  logic contention;

  int checks = 0;
  int failures = 0;
  item_t sb[$];
  event  pushed;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr18 #(.W(W)) u_bus_xcvr18 (
    .clk(clk), .rst(rst),
    .a_din(a_din), .le_ab(le_ab), .stb_ab(stb_ab), .oe_ab(oe_ab),
    .b_dout(b_dout), .b_oe(b_oe),
    .b_din(b_din), .le_ba(le_ba), .stb_ba(stb_ba), .oe_ba_n(oe_ba_n),
    .a_dout(a_dout), .a_oe(a_oe), .contention(contention)
  );

  task automatic expect_val(input string req, input int sel, input logic [W-1:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
    ->pushed;
    #0.1;
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(pushed);
      while (sb.size() > 0) begin
        item_t it;
        logic [W-1:0] got;
        it = sb.pop_front();
        case (it.sel)
          0: got = b_dout;
          1: got = a_dout;
          2: got = b_oe;
          3: got = a_oe;
          default: got = {{(W-1){1'b0}}, contention};
        endcase
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s sel=%0d got=%h exp=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; a_din = '0; b_din = '0;
    le_ab = 0; stb_ab = 0; oe_ab = 0; le_ba = 0; stb_ba = 0; oe_ba_n = 1;
    a_din = 18'h3FFFF; b_din = 18'h3FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    expect_val("R1", 0, '0);
    expect_val("R1", 1, '0);
    expect_val("R7", 2, '0);
    expect_val("R8", 3, '0);
    expect_val("R10", 4, '0);

    // transparent A to B
    le_ab = 1; a_din = 18'h2AAAA; #0.5;
    expect_val("R2", 0, 18'h2AAAA);
    step(); a_din = 18'h15555; #0.5;
    expect_val("R2", 0, 18'h15555);
    // latch control falls: keeps the last transparent sample
    step(); le_ab = 0; a_din = 18'h3FFFF; #0.5;
    expect_val("R5", 0, 18'h15555);
    // hold with quiet strobe
    step(); a_din = 18'h00F0F; #0.5;
    expect_val("R4", 0, 18'h15555);
    // capture on strobe rise
    step(); stb_ab = 1; a_din = 18'h12345; #0.5;
    expect_val("R4", 0, 18'h15555);
    step(); a_din = 18'h0ABCD; #0.5;
    expect_val("R3", 0, 18'h12345);
    step();
    expect_val("R4", 0, 18'h12345);

    // strobe already high when latch control falls
    le_ab = 1; a_din = 18'h01111; #0.5;
    expect_val("R2", 0, 18'h01111);
    step(); le_ab = 0; a_din = 18'h02222; #0.5;
    expect_val("R6", 0, 18'h01111);
    step();
    expect_val("R6", 0, 18'h01111);
    stb_ab = 0;
    step(); stb_ab = 1;
    step();
    expect_val("R6", 0, 18'h02222);

    // output enables and contention
    oe_ab = 1; #0.5;
    expect_val("R7", 2, '1);
    expect_val("R10", 4, '0);
    oe_ba_n = 0; #0.5;
    expect_val("R8", 3, '1);
    expect_val("R10", 4, 18'h1);
    oe_ab = 0; #0.5;
    expect_val("R7", 2, '0);
    expect_val("R10", 4, '0);
    oe_ba_n = 1; #0.5;
    expect_val("R8", 3, '0);

    // B to A path
    step(); le_ba = 1; b_din = 18'h3C3C3; #0.5;
    expect_val("R9", 1, 18'h3C3C3);
    expect_val("R11", 0, 18'h02222);
    step(); le_ba = 0; b_din = 18'h00001; #0.5;
    expect_val("R9", 1, 18'h3C3C3);
    step(); stb_ba = 1; #0.5;
    expect_val("R9", 1, 18'h3C3C3);
    step();
    expect_val("R9", 1, 18'h00001);
    expect_val("R11", 0, 18'h02222);
    // A-side strobe activity leaves B-to-A output alone
    stb_ab = 0; a_din = 18'h35555;
    step(); stb_ab = 1;
    step();
    expect_val("R3", 0, 18'h35555);
    expect_val("R11", 1, 18'h00001);

    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule